// File: doc/BRIEF.md
# Three-Lane Serial-to-Parallel Frame Receiver

This block turns three serial data lanes back into 21-bit parallel words. A fourth lane carries a forwarded clock. The clock lane is sampled as if it were data, and its 0-to-1 transition marks where each frame begins. Every input is sampled on the rising edge of a bit clock that runs at seven times the frame rate, so each lane delivers seven bits per frame. A frame counts as complete once a second boundary arrives exactly seven samples after the first one. The receiver then loads the frame into an output register and generates a parallel output strobe whose rising edge marks the word as valid.

The receiver holds its last good word rather than clearing it. The word and the strobe stay as they are in three cases: while the active-low power-down input is low, while the forwarded clock is missing, and while the boundary positions disagree. After each of these events, and after reset, the receiver throws away a configurable number of complete frames before it presents new words. This gives the upstream clock time to settle.

Top module: `rx_deser7`

## Requirements
- R1: Lane k sample j of a frame (j = 0 is the first sample after the boundary) appears on output bit 7k+j, so the first-received sample of each lane lands in the lowest bit of that lane's 7-bit group.
- R2: A frame boundary is a sample where the clock lane reads 1 and the previous sample read 0. A word is produced only for a frame that lies between two boundaries exactly BITS samples apart.
- R3: `par_data` changes only in the cycle that follows an accepted frame boundary.
- R4: `par_clk` is low when a new word appears, rises exactly 3 bit-clock cycles later, and stays high with `par_data` stable until the next word arrives.
- R5: While `pd_n` is low, no word is captured and `par_data` and `par_clk` keep their values.
- R6: If the clock lane shows no boundary at the expected sample, `par_data` and `par_clk` freeze, and no new word appears until alignment is regained.
- R7: After reset, after `pd_n` returns high, and after a lost boundary, the first LOCK_FRAMES complete frames are discarded. The next complete frame is the first one output.
- R8: During reset and afterwards, `par_data` and `par_clk` stay 0 until the first word is captured.
- R9: A boundary that arrives at the wrong sample position becomes the new reference for frame timing and restarts the discard count of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven samples per frame |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Active-low power-down; freezes the outputs |
| ser_lane | input | LANES | Serial data lanes, one sample per clock |
| ser_clk | input | 1 | Sampled forwarded clock lane |
| par_data | output | LANES*BITS | Rebuilt parallel word |
| par_clk | output | 1 | Parallel strobe; rising edge marks valid `par_data` |

## Verification
The bench keeps the default geometry of three lanes and seven bits per lane. It reduces LOCK_FRAMES from 1024 to 2, which makes the discard window short enough to count frame by frame after reset, after power-down and after a misplaced boundary. Bursts of distinct words are sent with single-bit corner words, so any lane or bit misplacement shows up at the output. A glitched clock-lane pattern and a stretch with the clock lane held low reach the realignment and freeze paths.

// File: rtl/rx_des_pkg.sv
package rx_des_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } link_st_e;

  // strobe rise delay, in bit clocks, after a new word appears
  function automatic int rise_delay(input int bits);
    return (bits >= 3) ? (bits - 1) / 2 : 1;
  endfunction

  function automatic int max1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/rx_lane_shift.sv
module rx_lane_shift #(
  parameter int BITS = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_in,
  output logic [BITS-1:0] frame_o
);

  logic [BITS-1:0] sh_q;

  // newest sample enters at the top; after BITS shifts the oldest sits at bit 0
  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {bit_in, sh_q[BITS-1:1]};
  end

  assign frame_o = sh_q;

endmodule

// File: rtl/rx_frame_align.sv
module rx_frame_align
  import rx_des_pkg::*;
#(
  parameter int BITS        = 7,
  parameter int LOCK_FRAMES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  input  logic ser_clk,
  output logic cap_en,
  output logic rise_en
);

  localparam int SPW     = max1($clog2(BITS));
  localparam int CW      = max1($clog2(LOCK_FRAMES + 2));
  localparam int LAST    = BITS - 1;
  localparam int RISE_AT = rise_delay(BITS) - 1;
  localparam int LF_M1   = (LOCK_FRAMES > 0) ? LOCK_FRAMES - 1 : 0;
  localparam link_st_e RESTART = (LOCK_FRAMES == 0) ? ST_RUN : ST_SETTLE;

  logic           ck_prev_q;
  logic [SPW-1:0] sp_q, sp_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  link_st_e       st_q, st_d;
  logic           live_q, live_d;
  logic           cap_d;

  logic edge_w, slot_w, on_time, off_time, miss;

  assign edge_w   = ser_clk & ~ck_prev_q;
  assign slot_w   = (sp_q == SPW'(LAST));
  assign on_time  = edge_w & slot_w;
  assign off_time = edge_w & ~slot_w;
  assign miss     = ~edge_w & slot_w;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sp_d   = sp_q;
    live_d = live_q;
    cap_d  = 1'b0;
    if (!pd_n) begin
      st_d   = ST_HUNT;
      live_d = 1'b0;
    end else begin
      case (st_q)
        ST_HUNT: begin
          if (edge_w) begin
            sp_d  = '0;
            cnt_d = '0;
            st_d  = RESTART;
          end
        end
        ST_SETTLE, ST_RUN: begin
          if (on_time) begin
            sp_d = '0;
            if (st_q == ST_SETTLE) begin
              cnt_d = cnt_q + CW'(1);
              if (cnt_q == CW'(LF_M1)) st_d = ST_RUN;
            end else begin
              cap_d  = 1'b1;
              live_d = 1'b1;
            end
          end else if (off_time) begin
            sp_d   = '0;
            cnt_d  = '0;
            st_d   = RESTART;
            live_d = 1'b0;
          end else if (miss) begin
            st_d   = ST_HUNT;
            live_d = 1'b0;
          end else begin
            sp_d = sp_q + SPW'(1);
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_prev_q <= 1'b0;
      sp_q      <= '0;
      cnt_q     <= '0;
      st_q      <= ST_HUNT;
      live_q    <= 1'b0;
    end else begin
      ck_prev_q <= ser_clk;
      sp_q      <= sp_d;
      cnt_q     <= cnt_d;
      st_q      <= st_d;
      live_q    <= live_d;
    end
  end

  assign cap_en  = cap_d;
  assign rise_en = pd_n & (st_q == ST_RUN) & live_q & ~edge_w &
                   (sp_q == SPW'(RISE_AT));

  // R2: the sample position inside a frame never leaves 0..BITS-1
  p_slot_range_r2: assert property (@(posedge clk) disable iff (rst)
    sp_q <= SPW'(LAST));

endmodule

// File: rtl/rx_word_out.sv
module rx_word_out #(
  parameter int WORD = 21
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic            rise_en,
  input  logic [WORD-1:0] frame_in,
  output logic [WORD-1:0] word_o,
  output logic            pclk_o
);

  logic [WORD-1:0] word_q;
  logic            pclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      pclk_q <= 1'b0;
    end else if (cap_en) begin
      word_q <= frame_in;
      pclk_q <= 1'b0;
    end else if (rise_en) begin
      pclk_q <= 1'b1;
    end
  end

  assign word_o = word_q;
  assign pclk_o = pclk_q;

  // R3: the word only moves right after the aligner accepted a frame
  p_upd_on_cap_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_q) |-> $past(cap_en));

endmodule

// File: rtl/rx_deser7.sv
module rx_deser7 #(
  parameter int LANES       = 3,
  parameter int BITS        = 7,
  parameter int LOCK_FRAMES = 1024
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pd_n,
  input  logic [LANES-1:0]      ser_lane,
  input  logic                  ser_clk,
  output logic [LANES*BITS-1:0] par_data,
  output logic                  par_clk
);

  localparam int WORD = LANES * BITS;

  logic [WORD-1:0] frame_all;
  logic            cap_en;
  logic            rise_en;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    rx_lane_shift #(.BITS(BITS)) u_shift (
      .clk    (clk),
      .rst    (rst),
      .bit_in (ser_lane[k]),
      .frame_o(frame_all[k*BITS +: BITS])
    );
  end

  rx_frame_align #(.BITS(BITS), .LOCK_FRAMES(LOCK_FRAMES)) u_align (
    .clk    (clk),
    .rst    (rst),
    .pd_n   (pd_n),
    .ser_clk(ser_clk),
    .cap_en (cap_en),
    .rise_en(rise_en)
  );

  rx_word_out #(.WORD(WORD)) u_out (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (cap_en),
    .rise_en (rise_en),
    .frame_in(frame_all),
    .word_o  (par_data),
    .pclk_o  (par_clk)
  );

  // R2: a capture coincides with a 0-to-1 step on the clock lane
  p_cap_on_edge_r2: assert property (@(posedge clk) disable iff (rst)
    cap_en |-> (ser_clk && !$past(ser_clk)));

  // R4: data is stable for as long as the strobe stays high
  p_hi_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (par_clk && $past(par_clk)) |-> $stable(par_data));

  // R5: no capture while powered down
  p_nocap_pd_r5: assert property (@(posedge clk) disable iff (rst)
    !pd_n |-> !cap_en);

  // R5: outputs frozen the cycle after power-down was sampled
  p_hold_pd_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(pd_n) && !$past(rst)) |-> ($stable(par_data) && $stable(par_clk)));

  // R8: reset leaves both outputs at zero
  p_zero_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (par_data == '0 && !par_clk));

endmodule

// File: tb/sim_rx_deser7.sv
module sim_rx_deser7;
  localparam int LANES = 3;
  localparam int BITS  = 7;
  localparam int LOCK  = 2;
  localparam int WORD  = LANES * BITS;
  localparam logic [BITS-1:0] PAT    = 7'b0001111;
  localparam logic [BITS-1:0] GLITCH = 7'b0011110;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pd_n = 1'b1;
  logic             ser_clk = 1'b0;
  logic [LANES-1:0] ser_lane = '0;
  logic [WORD-1:0]  par_data;
  logic             par_clk;

  always #10 clk = ~clk;

  rx_deser7 #(.LANES(LANES), .BITS(BITS), .LOCK_FRAMES(LOCK)) u0 (
    .clk(clk), .rst(rst), .pd_n(pd_n), .ser_lane(ser_lane),
    .ser_clk(ser_clk), .par_data(par_data), .par_clk(par_clk)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [WORD-1:0] seen_q[$];
  int              gap_q[$];
  logic [WORD-1:0] exp_q[$];
  int              gap = 0;
  logic            last_pclk = 1'b0;
  logic [WORD-1:0] last_data = '0;

  // monitor: records each strobe rise and the cycles since the word changed
  always @(negedge clk) begin
    if (rst) begin
      gap = 0; last_pclk = 1'b0; last_data = '0;
    end else begin
      if (par_data !== last_data) gap = 0;
      else gap++;
      if (par_clk && !last_pclk) begin
        seen_q.push_back(par_data);
        gap_q.push_back(gap);
      end
      last_pclk = par_clk;
      last_data = par_data;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [WORD-1:0] act, input logic [WORD-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [WORD-1:0] mk(input int i);
    return WORD'(32'h5A3C1 + i * 32'h00012B47);
  endfunction

  task automatic drive(input logic [LANES-1:0] d, input logic c, input logic p);
    @(negedge clk);
    ser_lane = d;
    ser_clk  = c;
    pd_n     = p;
  endtask

  // sample j of lane k carries word bit k*BITS+j (R1 mapping)
  task automatic send_frame(input logic [WORD-1:0] w, input logic [BITS-1:0] pat,
                            input logic p);
    for (int j = 0; j < BITS; j++) begin
      logic [LANES-1:0] d;
      for (int k = 0; k < LANES; k++) d[k] = w[k*BITS + j];
      drive(d, pat[j], p);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) drive('0, 1'b0, 1'b1);
  endtask

  task automatic compare(input string tag);
    check(seen_q.size() == exp_q.size(), tag, WORD'(seen_q.size()), WORD'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < seen_q.size(); i++)
      check(seen_q[i] == exp_q[i], tag, seen_q[i], exp_q[i]);
    for (int i = 0; i < gap_q.size(); i++)
      check(gap_q[i] == 3, "R4", WORD'(gap_q[i]), WORD'(3));
    seen_q.delete(); gap_q.delete(); exp_q.delete();
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    check(par_data == '0, "R8", par_data, '0);
    check(par_clk == 1'b0, "R8", WORD'(par_clk), '0);
    for (int i = 0; i < LOCK + 1; i++) send_frame(mk(100 + i), PAT, 1'b1);
    idle(12);
    check(seen_q.size() == 0, "R7", WORD'(seen_q.size()), '0);
    check(par_data == '0, "R8", par_data, '0);
  endtask

  logic [WORD-1:0] basic_w [6];

  task automatic t_basic;
    basic_w[0] = mk(1);
    basic_w[1] = mk(2);
    basic_w[2] = 21'h000080;
    basic_w[3] = 21'h100000;
    basic_w[4] = 21'h000001;
    basic_w[5] = 21'h155555;
    for (int i = 0; i < 6; i++) send_frame(basic_w[i], PAT, 1'b1);
    idle(12);
    for (int i = 2; i < 5; i++) exp_q.push_back(basic_w[i]);
    compare("R1");
  endtask

  task automatic t_stop;
    idle(40);
    check(seen_q.size() == 0, "R6", WORD'(seen_q.size()), '0);
    check(par_data == basic_w[4], "R6", par_data, basic_w[4]);
    check(par_clk == 1'b1, "R6", WORD'(par_clk), WORD'(1));
  endtask

  task automatic t_pd;
    for (int i = 0; i < 13; i++) begin
      send_frame(mk(200 + i), PAT, !(i >= 5 && i <= 7));
      if (i == 7) begin
        check(par_data == mk(203), "R5", par_data, mk(203));
        check(par_clk == 1'b1, "R5", WORD'(par_clk), WORD'(1));
        check(seen_q.size() == 2, "R5", WORD'(seen_q.size()), WORD'(2));
      end
    end
    idle(12);
    exp_q.push_back(mk(202));
    exp_q.push_back(mk(203));
    exp_q.push_back(mk(210));
    exp_q.push_back(mk(211));
    compare("R7");
  endtask

  task automatic t_glitch;
    for (int i = 0; i < 10; i++)
      send_frame(mk(300 + i), (i == 4) ? GLITCH : PAT, 1'b1);
    idle(12);
    check(seen_q.size() == 3, "R9", WORD'(seen_q.size()), WORD'(3));
    exp_q.push_back(mk(302));
    exp_q.push_back(mk(307));
    exp_q.push_back(mk(308));
    compare("R2");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_stop();
    t_pd();
    t_glitch();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule